// File: doc/BRIEF.md
# Per-Voice Interrupt Source Encoder

This block collects interrupt requests from a bank of synthesizer voices in two classes, waveform-end and volume-ramp-end, and hands them to the host one at a time. Each voice raises a request with a one-cycle set pulse on its class input. The host services one request by writing the service code 0x8F to the function-select register. The block then picks one pending request, clears it, updates a status byte that names the voice and its class, and pulses a clear strobe for that voice's flag in the per-voice register file.

Two summary bits in the global interrupt status byte show whether each class still has requests pending. The other bits of that byte come from sources outside the block. The interrupt line is high whenever any bit of the global status byte is set. While the chip's run bit is low, both pending vectors and both summary bits are held clear.

Top module: `voice_irq_encoder`

## Requirements
- R1: After reset the status byte is 0xE8, both summary bits are 0, no flag-clear strobe is active, and with external status 0 the interrupt line is low.
- R2: A set pulse on a voice marks it pending for its class. From the next cycle the class summary bit is high: bit 5 of the global status for waveform-end, bit 6 for ramp-end. The interrupt line is also high from that cycle.
- R3: A service happens only in a cycle where the select write strobe is high and the select data equals 0x8F. Any other write, or the data 0x8F without the strobe, leaves the status byte, the pending vectors and the summary bits unchanged.
- R4: Each service write serves at most one request, and each later write serves the next one.
- R5: If any waveform-end request is pending, the lowest-numbered pending voice is served. Its bit is cleared and the status byte becomes the voice number OR 0x60 (bits 7:5 = 011, bits 4:0 = voice).
- R6: Ramp-end requests are served only when no waveform-end request is pending. The lowest-numbered pending voice is served, its bit is cleared, and the status byte becomes the voice number OR 0x80 (bits 7:5 = 100).
- R7: A service write with nothing pending sets the status byte to 0xE8.
- R8: When a service empties the waveform-end vector, bit 5 of the global status clears. When a service empties the ramp-end vector, bit 6 clears.
- R9: The global status byte carries the external status on bits 7 and 4:0, and the two summary bits on bits 5 and 6. External bits 5 and 6 are ignored. The interrupt line is high exactly when this byte is nonzero.
- R10: One cycle after a service, exactly one flag-clear strobe bit is high for one cycle: the served voice in the served class.
- R11: If a set pulse for the voice being served arrives in the service cycle, the voice stays pending and no flag-clear strobe is issued. The status byte still names that voice.
- R12: While the run input is low, both pending vectors and both summary bits are cleared, and set pulses and service writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Chip run bit; low clears and freezes the pending state |
| wave_set_i | input | 31 | Per-voice waveform-end set pulses |
| ramp_set_i | input | 31 | Per-voice ramp-end set pulses |
| sel_we_i | input | 1 | Function-select register write strobe |
| sel_data_i | input | 8 | Function-select write data |
| ext_stat_i | input | 8 | Global status bits from other sources (bits 5 and 6 unused) |
| status_o | output | 8 | Served-voice status byte |
| gstat_o | output | 8 | Global interrupt status byte |
| irq_o | output | 1 | Interrupt line |
| wave_flag_clr_o | output | 31 | One-cycle clear strobe for a voice's waveform-end flag |
| ramp_flag_clr_o | output | 31 | One-cycle clear strobe for a voice's ramp-end flag |

## Verification
The bench loads both classes together and drains them. A design that checked ramp requests first, or served the highest voice, would return status codes in the wrong order. Voices 0 and 30 are tested to catch priority or index-width slips at the ends of the vector, and a full drain of all 31 voices shows whether a design served two requests per write or dropped one. A set pulse that arrives in the same cycle as the service of that voice shows whether the clear wrongly wins and the request is lost. Select writes with the wrong code, external bits 5 and 6, and a low run input test whether a design leaks a service or a summary bit where none is due.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam logic [7:0] SVC_CODE  = 8'h8F;
  localparam logic [7:0] IDLE_CODE = 8'hE8;
  localparam logic [7:0] WAVE_BASE = 8'h60;
  localparam logic [7:0] RAMP_BASE = 8'h80;
  localparam int         WAVE_SUM_BIT = 5;
  localparam int         RAMP_SUM_BIT = 6;
  localparam int         NUM_CLASSES  = 2;
  typedef enum logic [0:0] {CLS_WAVE = 1'b0, CLS_RAMP = 1'b1} irq_class_e;
endpackage

// File: rtl/voice_irq_prio.sv
module voice_irq_prio #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IW'(i);
        onehot_o = N'(1) << i;
      end
    end
    valid_o = |req_i;
  end
endmodule

// File: rtl/voice_irq_bank.sv
module voice_irq_bank #(
  parameter int N = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o,
  output logic         sum_o,
  output logic [N-1:0] flag_clr_o
);
  logic [N-1:0] pend_q, pend_d;
  logic         sum_q, sum_d;
  logic [N-1:0] fclr_q, fclr_d;

  always_comb begin
    pend_d = pend_q;
    sum_d  = sum_q;
    fclr_d = '0;
    if (!run_i) begin
      pend_d = '0;
      sum_d  = 1'b0;
    end else begin
      if (clr_en_i) begin
        pend_d = pend_q & ~clr_mask_i;
        fclr_d = clr_mask_i & ~set_i;   // a fresh set keeps the flag
      end
      pend_d = pend_d | set_i;
      if (|set_i) sum_d = 1'b1;
      else if (clr_en_i && pend_d == '0) sum_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sum_q  <= 1'b0;
      fclr_q <= '0;
    end else begin
      pend_q <= pend_d;
      sum_q  <= sum_d;
      fclr_q <= fclr_d;
    end
  end

  assign pend_o     = pend_q;
  assign sum_o      = sum_q;
  assign flag_clr_o = fclr_q;

  assert_sum_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q == (|pend_q));
  assert_run_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pend_q == '0) && !sum_q);
  assert_set_sticks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && |set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  assert_single_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fclr_q));
endmodule

// File: rtl/voice_irq_encoder.sv
module voice_irq_encoder
  import voice_irq_pkg::*;
#(
  parameter int NUM_VOICES = 31
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [NUM_VOICES-1:0] wave_set_i,
  input  logic [NUM_VOICES-1:0] ramp_set_i,
  input  logic                  sel_we_i,
  input  logic [7:0]            sel_data_i,
  input  logic [7:0]            ext_stat_i,
  output logic [7:0]            status_o,
  output logic [7:0]            gstat_o,
  output logic                  irq_o,
  output logic [NUM_VOICES-1:0] wave_flag_clr_o,
  output logic [NUM_VOICES-1:0] ramp_flag_clr_o
);
  localparam int IW = $clog2(NUM_VOICES);

  logic [NUM_CLASSES-1:0][NUM_VOICES-1:0] set_v, pend_v, mask_v, fclr_v;
  logic [NUM_CLASSES-1:0][IW-1:0]         idx_v;
  logic [NUM_CLASSES-1:0]                 valid_v, clr_en_v, sum_v;
  logic                                   svc;
  logic [7:0]                             status_q, status_d;

  assign set_v[CLS_WAVE] = wave_set_i;
  assign set_v[CLS_RAMP] = ramp_set_i;
  assign svc = run_i && sel_we_i && (sel_data_i == SVC_CODE);

  // waveform class has strict priority over ramp class
  assign clr_en_v[CLS_WAVE] = svc && valid_v[CLS_WAVE];
  assign clr_en_v[CLS_RAMP] = svc && !valid_v[CLS_WAVE] && valid_v[CLS_RAMP];

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    voice_irq_prio #(.N(NUM_VOICES), .IW(IW)) i_prio (
      .req_i   (pend_v[c]),
      .valid_o (valid_v[c]),
      .idx_o   (idx_v[c]),
      .onehot_o(mask_v[c])
    );
    voice_irq_bank #(.N(NUM_VOICES)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_i),
      .set_i     (set_v[c]),
      .clr_en_i  (clr_en_v[c]),
      .clr_mask_i(mask_v[c]),
      .pend_o    (pend_v[c]),
      .sum_o     (sum_v[c]),
      .flag_clr_o(fclr_v[c])
    );
  end

  always_comb begin
    status_d = status_q;
    if (svc) begin
      if (clr_en_v[CLS_WAVE])      status_d = WAVE_BASE | 8'(idx_v[CLS_WAVE]);
      else if (clr_en_v[CLS_RAMP]) status_d = RAMP_BASE | 8'(idx_v[CLS_RAMP]);
      else                         status_d = IDLE_CODE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= IDLE_CODE;
    else         status_q <= status_d;
  end

  always_comb begin
    gstat_o = ext_stat_i;
    gstat_o[WAVE_SUM_BIT] = sum_v[CLS_WAVE];
    gstat_o[RAMP_SUM_BIT] = sum_v[CLS_RAMP];
  end

  assign irq_o           = |gstat_o;
  assign status_o        = status_q;
  assign wave_flag_clr_o = fclr_v[CLS_WAVE];
  assign ramp_flag_clr_o = fclr_v[CLS_RAMP];

  assert_idle_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && pend_v == '0) |=> status_q == IDLE_CODE);
  assert_wave_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && |pend_v[CLS_WAVE]) |=> status_q[7:5] == 3'b011);
  assert_ramp_tag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && pend_v[CLS_WAVE] == '0 && |pend_v[CLS_RAMP]) |=> status_q[7:5] == 3'b100);
  assert_hold_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc |=> $stable(status_q));
  assert_one_served_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> $countones({wave_flag_clr_o, ramp_flag_clr_o}) <= 1);
  assert_clr_needs_svc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc |=> ({wave_flag_clr_o, ramp_flag_clr_o} == '0));
endmodule

// File: tb/test_voice_irq_encoder.sv
module test_voice_irq_encoder;
  localparam int N = 31;

  typedef struct packed {
    logic [7:0]   st;
    logic [N-1:0] w;
    logic [N-1:0] r;
  } exp_t;

  logic         clk = 1'b0, rst_n = 1'b0, run = 1'b1;
  logic [N-1:0] wset = '0, rset = '0;
  logic         sel_we = 1'b0;
  logic [7:0]   sel_data = '0, ext = '0;
  logic [7:0]   status, gstat;
  logic         irq;
  logic [N-1:0] wclr, rclr;

  logic [N-1:0] wave_m = '0, ramp_m = '0;
  exp_t         exp_q[$];
  exp_t         mon_e;
  int           n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  voice_irq_encoder #(.NUM_VOICES(N)) i_voice_irq_encoder (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .wave_set_i(wset), .ramp_set_i(rset),
    .sel_we_i(sel_we), .sel_data_i(sel_data), .ext_stat_i(ext),
    .status_o(status), .gstat_o(gstat), .irq_o(irq),
    .wave_flag_clr_o(wclr), .ramp_flag_clr_o(rclr));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: compares each service result against the scoreboard
  always @(posedge clk) begin
    if (rst_n && run && sel_we && sel_data == 8'h8F) begin
      #1;
      if (exp_q.size() == 0) check(1'b0, "R4 queue", 0, 1);
      else begin
        mon_e = exp_q.pop_front();
        check(status == mon_e.st, "R5/R6/R7 status", 64'(status), 64'(mon_e.st));
        check(wclr == mon_e.w, "R10/R11 wave clr", 64'(wclr), 64'(mon_e.w));
        check(rclr == mon_e.r, "R10/R11 ramp clr", 64'(rclr), 64'(mon_e.r));
      end
    end
  end

  // driver: one cycle of stimulus, model update, scoreboard push
  task automatic step(input bit we, input logic [7:0] d, input logic [N-1:0] ws, input logic [N-1:0] rs);
    exp_t e;
    bit   found;
    @(negedge clk);
    sel_we = we; sel_data = d; wset = ws; rset = rs;
    if (!run) begin
      wave_m = '0; ramp_m = '0;
    end else begin
      if (we && d == 8'h8F) begin
        e = '0; e.st = 8'hE8; found = 0;
        for (int i = 0; i < N; i++)
          if (!found && wave_m[i]) begin
            found = 1; e.st = 8'h60 | 8'(i);
            wave_m[i] = 1'b0; e.w[i] = !ws[i];
          end
        for (int i = 0; i < N; i++)
          if (!found && ramp_m[i]) begin
            found = 1; e.st = 8'h80 | 8'(i);
            ramp_m[i] = 1'b0; e.r[i] = !rs[i];
          end
        exp_q.push_back(e);
      end
      wave_m |= ws; ramp_m |= rs;
    end
    @(negedge clk);
    sel_we = 1'b0; sel_data = '0; wset = '0; rset = '0;
  endtask

  task automatic serve(); step(1'b1, 8'h8F, '0, '0); endtask

  task automatic chk_g(input string req);
    logic [7:0] g;
    g = ext;
    g[5] = |wave_m;
    g[6] = |ramp_m;
    check(gstat == g, req, 64'(gstat), 64'(g));
    check(irq == (g != 0), req, 64'(irq), 64'(g != 0));
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 8'hE8, "R1 status", 64'(status), 64'hE8);
    check(wclr == '0 && rclr == '0, "R1 clr", 64'(wclr | rclr), 0);
    chk_g("R1 gstat/irq");

    // R7 nothing pending
    serve();

    // R2 set pulses
    step(1'b0, 8'h00, (N'(1) << 7) | (N'(1) << 3), N'(1) << 2);
    chk_g("R2 summary/irq");

    // R3 wrong code or no strobe
    step(1'b1, 8'h8E, '0, '0);
    step(1'b0, 8'h8F, '0, '0);
    @(negedge clk);
    check(status == 8'hE8, "R3 status held", 64'(status), 64'hE8);
    check(wclr == '0 && rclr == '0, "R3 no clr", 64'(wclr | rclr), 0);
    chk_g("R3 pending held");

    // R5 wave first, lowest voice; R8 summary drop; R6 ramp after
    serve();
    chk_g("R4 one served");
    serve();
    chk_g("R8 wave summary clear");
    serve();
    chk_g("R8 ramp summary clear");
    serve();

    // R5 end voices
    step(1'b0, 8'h00, (N'(1) << 30) | N'(1), N'(1) << 30);
    serve(); serve();
    chk_g("R8 wave empty, ramp kept");
    serve();
    chk_g("R6 ramp voice 30 served");

    // R11 set in the service cycle
    step(1'b0, 8'h00, N'(1) << 4, '0);
    step(1'b1, 8'h8F, N'(1) << 4, '0);
    chk_g("R11 still pending");
    serve();
    chk_g("R11 drained");

    // R9 external bits
    ext = 8'h01;
    @(negedge clk);
    chk_g("R9 external bit0");
    ext = 8'h60;
    @(negedge clk);
    chk_g("R9 ext bits 5/6 ignored");
    ext = 8'h80;
    step(1'b0, 8'h00, '0, N'(1) << 9);
    chk_g("R9 ext bit7 with ramp");
    ext = 8'h00;
    serve();

    // R12 run low
    step(1'b0, 8'h00, N'(1) << 11, N'(1) << 12);
    run = 1'b0;
    step(1'b0, 8'h00, N'(1) << 13, '0);
    step(1'b1, 8'h8F, '0, '0);
    chk_g("R12 cleared and ignored");
    check(status == 8'h89, "R12 status frozen", 64'(status), 64'h89);
    run = 1'b1;
    serve();

    // R4 full drain of both classes
    step(1'b0, 8'h00, '1, N'(1) << 5);
    for (int i = 0; i < N + 2; i++) serve();
    chk_g("R4 full drain");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard empty", 64'(exp_q.size()), 0);
    finish_up();
  end
endmodule